// File: doc/BRIEF.md
# Mode Register Write Issuer with Rank Mirroring

This block turns a request to program one DRAM mode register into the exact sequence of strobes that a memory controller's mode-register port expects. A request carries a register index, a 16-bit data word, a rank code and a write-type bit. Two configuration inputs give the DRAM family and whether the second rank is wired with mirrored address and bank lines. When mirroring applies, the index and data are bit-permuted before the command is loaded, so the DRAM receives the value software intended.

Each write first pulses the controller's self-clearing trigger and waits until the controller's busy flag reads low on two polls in a row. Only then does it load the command word and data. A separate trigger pulse then starts the write, and the block waits for busy to drop. A walker built on the same sequencer reprograms every rank from a per-performance-state table. It handles ranks in ascending order. For each rank it writes registers 0 to 5 from table entries 0 to 5, then register 6 from table entry 7.

Top module: `mrw_issuer`

## Requirements
- R1: Mirroring is applied only when cfg_mirror is 1 and the rank code of the write equals 2. In every other case the loaded index and data equal the request's index and data.
- R2: When mirroring applies, index bit 2 is unchanged and index bits 0 and 1 trade places.
- R3: When mirroring applies with cfg_ddr4 = 1, data bits 0, 1, 2, 9, 10 and 12 are unchanged. The pairs 3/4, 5/6, 7/8 and 11/13 trade places, and loaded bits 14 and 15 are 0.
- R4: When mirroring applies with cfg_ddr4 = 0, data bits 0 to 2 and 9 to 15 are unchanged, and only the pairs 3/4, 5/6 and 7/8 trade places.
- R5: The load strobe (ctl_cmd_we and ctl_data_we high together) presents a command word with the write type at bit 0, the rank code at bits 7:4, the (possibly mirrored) index at bits 14:12 and bit 31 at 0. ctl_data carries the (possibly mirrored) data in the same cycle.
- R6: Before each load, the block issues a trigger strobe (ctl_cmd_we with ctl_cmd[31] = 1). Busy must then be sampled low in each of the two cycles just before the load cycle.
- R7: In the cycle after the load, a trigger strobe repeats bits 30:0 of the loaded word with bit 31 set. wr_done pulses for one cycle after busy is next sampled low, and ready is high in that same cycle.
- R8: A walk with pstate P and rank count N performs 7·N writes, all of write type 0. Ranks run from 1 to N. Within each rank, registers 0 to 5 take table entries 0 to 5 and register 6 takes entry 7. The table is addressed with tbl_pstate = P, and mirroring follows R1 to R4 per rank.
- R9: walk_done pulses for exactly one cycle: in the cycle after the final wr_done of the walk, or in the cycle after the start when N = 0. A walk with N = 0 makes no write.
- R10: walk_start and req_valid are ignored while ready is low, so a start during a walk changes neither the number nor the content of that walk's writes. walk_start wins when both arrive together.
- R11: After reset, ready is 1 and ctl_cmd_we, ctl_data_we, wr_done and walk_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mirror | input | 1 | Rank 2 uses mirrored address/bank wiring |
| cfg_ddr4 | input | 1 | 1 selects the DDR4 data permutation, 0 the other family |
| req_valid | input | 1 | Single write request, taken when ready is 1 |
| req_idx | input | 3 | Mode register index |
| req_data | input | 16 | Mode register data |
| req_rank | input | 4 | Rank code |
| req_type | input | 1 | Write type bit |
| ready | output | 1 | No write or walk in progress |
| wr_done | output | 1 | One-cycle pulse when a write completes |
| walk_start | input | 1 | Start a table walk, taken when ready is 1 |
| walk_pstate | input | 2 | Performance state selecting the table row |
| walk_ranks | input | 4 | Number of ranks to walk |
| walk_done | output | 1 | One-cycle pulse when the walk finishes |
| tbl_pstate | output | 2 | Table row being read |
| tbl_entry | output | 3 | Table entry being read |
| tbl_data | input | 16 | Table contents at tbl_pstate/tbl_entry, same cycle |
| ctl_cmd_we | output | 1 | Command register write strobe |
| ctl_data_we | output | 1 | Data register write strobe |
| ctl_cmd | output | 32 | Command word |
| ctl_data | output | 16 | Data word |
| ctl_busy | input | 1 | Controller busy with a mode-register transaction |

## Verification
The bench sweeps every index, the rank codes 0 to 3, both mirror settings, both DRAM families and walking-one data. It compares the loaded word against a permutation it builds from swap pairs. A design that mirrors the wrong rank, swaps the wrong pair or keeps bits 14/15 for DDR4 shows up there as a wrong index or data field. The bench's responder can drop busy for a single cycle in the middle of a busy period. A sequencer that checks busy only once would then load while busy is still high. Walks cover rank counts 0 to 4, and a start and a single request are injected mid-walk. A walker with the wrong order, the wrong entry for register 6, a restart or a late done pulse gives a wrong write log or wrong pulse timing.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  localparam int DATA_W      = 16;
  localparam int IDX_W       = 3;
  localparam int RANK_W      = 4;
  localparam int PS_W        = 2;
  localparam int ENT_W       = 3;
  localparam int STEP_W      = 3;
  localparam int CMD_W       = 32;
  localparam int TYPE_POS    = 0;
  localparam int RANK_POS    = 4;
  localparam int IDX_POS     = 12;
  localparam int TRIG_POS    = 31;
  localparam int LAST_STEP   = 6;
  localparam int LAST_ENTRY  = 7;
  localparam int MIRROR_RANK = 2;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
    logic [RANK_W-1:0] rank;
    logic              wtype;
  } mr_req_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_POLL1, S_POLL2, S_LOAD, S_TRIG, S_WAIT
  } seq_st_t;

  typedef enum logic [1:0] {
    W_IDLE, W_ISSUE, W_WAIT
  } walk_st_t;
endpackage

// File: rtl/mrw_rst_sync.sv
module mrw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mrw_mirror.sv
module mrw_mirror import mrw_pkg::*; #(
  parameter int MIR_RANK = MIRROR_RANK
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mirror_en,
  input  logic    ddr4,
  input  mr_req_t req_i,
  output mr_req_t req_o
);
  localparam int NPAIRS = 3;
  localparam int PAIR0  = 3;

  logic apply;
  assign apply = mirror_en && (req_i.rank == RANK_W'(MIR_RANK));

  logic [DATA_W-1:0] din, dout;
  logic [IDX_W-1:0]  iout;

  always_comb begin
    din  = req_i.data;
    dout = din;
    for (int p = 0; p < NPAIRS; p++) begin
      dout[PAIR0 + 2*p]     = din[PAIR0 + 2*p + 1];
      dout[PAIR0 + 2*p + 1] = din[PAIR0 + 2*p];
    end
    if (ddr4) begin
      dout[11]    = din[13];
      dout[13]    = din[11];
      dout[15:14] = 2'b00;
    end
    iout = {req_i.idx[IDX_W-1:2], req_i.idx[0], req_i.idx[1]};
  end

  always_comb begin
    req_o = req_i;
    if (apply) begin
      req_o.idx  = iout;
      req_o.data = dout;
    end
  end

  // R2: index permutation never changes how many bits are set
  p_idx_ones_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_o.idx) == $countones(req_i.idx));

  // R4: data permutation keeps the set-bit count unless DDR4 drops bits 15:14
  p_data_ones_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply || !ddr4 || (req_i.data[15:14] == 2'b00)) |->
      ($countones(req_o.data) == $countones(req_i.data)));
endmodule

// File: rtl/mrw_seq.sv
module mrw_seq import mrw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mr_req_t          req_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cmd_we,
  output logic             data_we,
  output logic [CMD_W-1:0] cmd,
  output logic [DATA_W-1:0] data,
  input  logic             ctl_busy
);
  seq_st_t          st_q, st_d;
  mr_req_t          req_q;
  logic             req_en;
  logic [CMD_W-1:0] cmd_q, load_word;
  logic             cmd_en;
  logic             done_q, done_d;

  always_comb begin
    load_word = '0;
    load_word[TYPE_POS]               = req_q.wtype;
    load_word[RANK_POS +: RANK_W]     = req_q.rank;
    load_word[IDX_POS  +: IDX_W]      = req_q.idx;
  end

  always_comb begin
    st_d   = st_q;
    req_en = 1'b0;
    cmd_en = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      S_IDLE:  if (start) begin st_d = S_PRE; req_en = 1'b1; end
      S_PRE:   st_d = S_POLL1;
      S_POLL1: if (!ctl_busy) st_d = S_POLL2;
      S_POLL2: st_d = ctl_busy ? S_POLL1 : S_LOAD;
      S_LOAD:  begin st_d = S_TRIG; cmd_en = 1'b1; end
      S_TRIG:  st_d = S_WAIT;
      S_WAIT:  if (!ctl_busy) begin st_d = S_IDLE; done_d = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      req_q  <= '0;
      cmd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (req_en) req_q <= req_i;
      if (cmd_en) cmd_q <= load_word;
    end
  end

  always_comb begin
    cmd_we  = 1'b0;
    data_we = 1'b0;
    cmd     = cmd_q;
    unique case (st_q)
      S_PRE:   begin cmd_we = 1'b1; cmd[TRIG_POS] = 1'b1; end
      S_LOAD:  begin cmd_we = 1'b1; data_we = 1'b1; cmd = load_word; end
      S_TRIG:  begin cmd_we = 1'b1; cmd[TRIG_POS] = 1'b1; end
      default: ;
    endcase
  end

  assign data   = req_q.data;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;

  // R6: a load only follows two cycles in which busy was low
  p_two_idle_polls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> ($past(!ctl_busy) && $past(!ctl_busy, 2)));

  // R7: the trigger right after the load repeats the loaded fields
  p_trig_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (cmd_we && cmd[TRIG_POS] && !data_we &&
                 (cmd[TRIG_POS-1:0] == $past(cmd[TRIG_POS-1:0]))));

  // R7: completion is reported only after busy was seen low
  p_done_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(!ctl_busy));

  // R5: the load word never carries the trigger bit
  p_load_no_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> !cmd[TRIG_POS]);
endmodule

// File: rtl/mrw_walker.sv
module mrw_walker import mrw_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PS_W-1:0]   pstate,
  input  logic [RANK_W-1:0] ranks,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              active,
  output logic              issue,
  output mr_req_t           wreq,
  output logic [PS_W-1:0]   tbl_pstate,
  output logic [ENT_W-1:0]  tbl_entry,
  output logic              done
);
  walk_st_t          st_q, st_d;
  logic [PS_W-1:0]   ps_q, ps_d;
  logic [RANK_W-1:0] nr_q, nr_d, rank_q, rank_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              last;

  assign last = (step_q == STEP_W'(LAST_STEP)) && (rank_q == nr_q);

  always_comb begin
    st_d   = st_q;
    ps_d   = ps_q;
    nr_d   = nr_q;
    rank_d = rank_q;
    step_d = step_q;
    done_d = 1'b0;
    issue  = 1'b0;
    unique case (st_q)
      W_IDLE: if (start) begin
        ps_d   = pstate;
        nr_d   = ranks;
        rank_d = RANK_W'(1);
        step_d = '0;
        if (ranks == '0) done_d = 1'b1;
        else             st_d   = W_ISSUE;
      end
      W_ISSUE: begin
        issue = 1'b1;
        st_d  = W_WAIT;
      end
      W_WAIT: if (seq_done) begin
        if (last) begin
          done_d = 1'b1;
          st_d   = W_IDLE;
        end else begin
          st_d = W_ISSUE;
          if (step_q == STEP_W'(LAST_STEP)) begin
            step_d = '0;
            rank_d = rank_q + RANK_W'(1);
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      ps_q   <= '0;
      nr_q   <= '0;
      rank_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ps_q   <= ps_d;
      nr_q   <= nr_d;
      rank_q <= rank_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign active     = (st_q != W_IDLE);
  assign tbl_pstate = ps_q;
  assign tbl_entry  = (step_q == STEP_W'(LAST_STEP)) ? ENT_W'(LAST_ENTRY)
                                                      : ENT_W'(step_q);
  assign wreq.idx   = IDX_W'(step_q);
  assign wreq.data  = tbl_data;
  assign wreq.rank  = rank_q;
  assign wreq.wtype = 1'b0;
  assign done       = done_q;

  // R9: the completion pulse lasts one cycle
  p_walk_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: while walking, the rank stays between 1 and the requested count
  p_rank_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((rank_q >= RANK_W'(1)) && (rank_q <= nr_q)));

  // R10: the table row is frozen for the whole walk
  p_pstate_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(tbl_pstate));
endmodule

// File: rtl/mrw_issuer.sv
module mrw_issuer import mrw_pkg::*; #(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mirror,
  input  logic              cfg_ddr4,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              req_type,
  output logic              ready,
  output logic              wr_done,
  input  logic              walk_start,
  input  logic [PS_W-1:0]   walk_pstate,
  input  logic [RANK_W-1:0] walk_ranks,
  output logic              walk_done,
  output logic [PS_W-1:0]   tbl_pstate,
  output logic [ENT_W-1:0]  tbl_entry,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              ctl_cmd_we,
  output logic              ctl_data_we,
  output logic [CMD_W-1:0]  ctl_cmd,
  output logic [DATA_W-1:0] ctl_data,
  input  logic              ctl_busy
);
  logic    rst_n_s;
  logic    seq_busy, seq_done, walk_active, walk_issue;
  logic    walk_acc, single_acc, seq_start;
  mr_req_t single_req, walk_req, raw_req, mir_req;

  mrw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  assign ready      = !seq_busy && !walk_active;
  assign walk_acc   = walk_start && ready;
  assign single_acc = req_valid && ready && !walk_start;
  assign seq_start  = walk_issue || single_acc;

  assign single_req.idx   = req_idx;
  assign single_req.data  = req_data;
  assign single_req.rank  = req_rank;
  assign single_req.wtype = req_type;
  assign raw_req = walk_active ? walk_req : single_req;

  mrw_walker u_walk (
    .clk(clk), .rst_n(rst_n_s), .start(walk_acc), .pstate(walk_pstate),
    .ranks(walk_ranks), .seq_done(seq_done), .tbl_data(tbl_data),
    .active(walk_active), .issue(walk_issue), .wreq(walk_req),
    .tbl_pstate(tbl_pstate), .tbl_entry(tbl_entry), .done(walk_done)
  );

  mrw_mirror u_mir (
    .clk(clk), .rst_n(rst_n_s), .mirror_en(cfg_mirror), .ddr4(cfg_ddr4),
    .req_i(raw_req), .req_o(mir_req)
  );

  mrw_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(seq_start), .req_i(mir_req),
    .busy_o(seq_busy), .done_o(seq_done), .cmd_we(ctl_cmd_we),
    .data_we(ctl_data_we), .cmd(ctl_cmd), .data(ctl_data),
    .ctl_busy(ctl_busy)
  );

  assign wr_done = seq_done;

  // R11: nothing is strobed while the block reports ready
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    ready |-> (!ctl_cmd_we && !ctl_data_we));
endmodule

// File: tb/sim_mrw_issuer.sv
module sim_mrw_issuer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mirror = 1'b0, cfg_ddr4 = 1'b0;
  logic        req_valid = 1'b0, req_type = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [15:0] req_data = '0;
  logic [3:0]  req_rank = '0;
  logic        walk_start = 1'b0;
  logic [1:0]  walk_pstate = '0;
  logic [3:0]  walk_ranks = '0;
  logic        ready, wr_done, walk_done, ctl_cmd_we, ctl_data_we;
  logic [1:0]  tbl_pstate;
  logic [2:0]  tbl_entry;
  logic [15:0] tbl_data, ctl_data;
  logic [31:0] ctl_cmd;
  logic        ctl_busy = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] tbl_f(logic [1:0] ps, logic [2:0] e);
    return (16'(ps) * 16'h3100) ^ (16'(e) * 16'h0247) ^ 16'h8421;
  endfunction
  assign tbl_data = tbl_f(tbl_pstate, tbl_entry);

  mrw_issuer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mirror(cfg_mirror), .cfg_ddr4(cfg_ddr4),
    .req_valid(req_valid), .req_idx(req_idx), .req_data(req_data),
    .req_rank(req_rank), .req_type(req_type), .ready(ready), .wr_done(wr_done),
    .walk_start(walk_start), .walk_pstate(walk_pstate), .walk_ranks(walk_ranks),
    .walk_done(walk_done), .tbl_pstate(tbl_pstate), .tbl_entry(tbl_entry),
    .tbl_data(tbl_data), .ctl_cmd_we(ctl_cmd_we), .ctl_data_we(ctl_data_we),
    .ctl_cmd(ctl_cmd), .ctl_data(ctl_data), .ctl_busy(ctl_busy)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // reference permutations built from swap pairs
  function automatic logic [15:0] ref_data(logic [15:0] d, bit ddr4);
    logic [15:0] o = '0;
    for (int i = 0; i < 16; i++) begin
      int j = i;
      if (i >= 3 && i <= 8) j = (i % 2 == 1) ? i + 1 : i - 1;
      else if (ddr4 && i == 11) j = 13;
      else if (ddr4 && i == 13) j = 11;
      if (!(ddr4 && i >= 14)) o[j] = d[i];
    end
    return o;
  endfunction

  function automatic logic [2:0] ref_idx(logic [2:0] x);
    return {x[2], x[0], x[1]};
  endfunction

  // responder and protocol monitor, all on the falling edge
  int  lat = 2;
  bit  glitch = 0;
  int  k = 1000;
  bit  b1 = 0, b2 = 0, pre_seen = 0, after_load = 0;
  logic [31:0] cap_cmd;
  logic [15:0] cap_data;
  logic [31:0] wlog_cmd [0:63];
  logic [15:0] wlog_data [0:63];
  int  wcount = 0, cyc = 0, last_wr = 0, wd_cyc = 0, wd_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (ctl_cmd_we && ctl_cmd[31]) k = 0;
    else if (k < 1000) k++;
    ctl_busy = (k >= 1 && k <= lat) || (glitch && k >= lat + 2 && k <= lat + 3);
    if (rst_n) begin
      if (wr_done) begin last_wr = cyc; pre_seen = 0; end
      if (walk_done) begin wd_cyc = cyc; wd_cnt++; end
      if (ctl_data_we) begin
        chk(!b1 && !b2, "R6 busy low twice before load", {30'd0, b2, b1}, 32'd0);
        chk(pre_seen, "R6 trigger before load", 32'(pre_seen), 32'd1);
        cap_cmd  = ctl_cmd;
        cap_data = ctl_data;
        if (wcount < 64) begin
          wlog_cmd[wcount]  = ctl_cmd;
          wlog_data[wcount] = ctl_data;
        end
        wcount++;
        after_load = 1;
      end else if (after_load) begin
        chk(ctl_cmd_we && ctl_cmd == (cap_cmd | 32'h8000_0000),
            "R7 trigger after load", ctl_cmd, cap_cmd | 32'h8000_0000);
        after_load = 0;
      end
      if (ctl_cmd_we && ctl_cmd[31]) pre_seen = 1;
    end
    b2 = b1;
    b1 = ctl_busy;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic single(logic [2:0] idx, logic [15:0] d, logic [3:0] rk,
                        logic ty, bit mir, bit ddr, int l, bit gl, string tag);
    logic [2:0]  ei;
    logic [15:0] ed;
    logic [31:0] ec;
    bit ap;
    while (!ready) @(negedge clk);
    cfg_mirror = mir; cfg_ddr4 = ddr; lat = l; glitch = gl;
    req_idx = idx; req_data = d; req_rank = rk; req_type = ty; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!wr_done) @(negedge clk);
    ap = mir && (rk == 4'd2);
    ei = ap ? ref_idx(idx) : idx;
    ed = ap ? ref_data(d, ddr) : d;
    ec = 32'(ty) | (32'(rk) << 4) | (32'(ei) << 12);
    chk(cap_cmd == ec, {tag, " cmd word"}, cap_cmd, ec);
    chk(cap_data == ed, {tag, " data"}, 32'(cap_data), 32'(ed));
    chk(ready, "R7 ready with wr_done", 32'(ready), 32'd1);
  endtask

  task automatic run_walk(logic [1:0] ps, int n, bit mir, bit ddr, bit intrude);
    int d0;
    logic [2:0]  s, e, ei;
    logic [3:0]  r;
    logic [15:0] ed;
    logic [31:0] ec;
    while (!ready) @(negedge clk);
    cfg_mirror = mir; cfg_ddr4 = ddr; lat = 2; glitch = 0;
    wcount = 0; d0 = wd_cnt;
    walk_pstate = ps; walk_ranks = 4'(n); walk_start = 1;
    @(negedge clk);
    walk_start = 0;
    if (intrude) begin
      repeat (6) @(negedge clk);
      walk_start = 1; walk_pstate = ps + 2'd1; walk_ranks = 4'd4;
      req_valid = 1; req_idx = 3'd1; req_rank = 4'd1;
      @(negedge clk);
      walk_start = 0; req_valid = 0;
    end
    while (!walk_done) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(wcount == 7 * n, "R8 R10 write count", 32'(wcount), 32'(7 * n));
    chk(wd_cnt - d0 == 1, "R9 one done pulse", 32'(wd_cnt - d0), 32'd1);
    if (n > 0)
      chk(wd_cyc - last_wr == 1, "R9 done timing", 32'(wd_cyc - last_wr), 32'd1);
    for (int i = 0; i < 7 * n && i < 64; i++) begin
      r  = 4'(1 + i / 7);
      s  = 3'(i % 7);
      e  = (s == 3'd6) ? 3'd7 : s;
      ei = (mir && r == 4'd2) ? ref_idx(s) : s;
      ed = (mir && r == 4'd2) ? ref_data(tbl_f(ps, e), ddr) : tbl_f(ps, e);
      ec = (32'(r) << 4) | (32'(ei) << 12);
      chk(wlog_cmd[i] == ec, "R8 walk cmd", wlog_cmd[i], ec);
      chk(wlog_data[i] == ed, "R8 walk data", 32'(wlog_data[i]), 32'(ed));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(ready, "R11 ready after reset", 32'(ready), 32'd1);
    chk(!ctl_cmd_we && !ctl_data_we, "R11 no strobes", {30'd0, ctl_cmd_we, ctl_data_we}, 32'd0);
    chk(!wr_done && !walk_done, "R11 no pulses", {30'd0, wr_done, walk_done}, 32'd0);

    // R1 R2 R3 R4 R5: sweep of index, rank, mirror, family and data
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int rk = 0; rk < 4; rk++)
          for (int ix = 0; ix < 8; ix++)
            for (int dv = 0; dv < 18; dv++) begin
              logic [15:0] d = (dv < 16) ? (16'd1 << dv) : (dv == 16 ? 16'hFFFF : 16'hA5C3);
              single(3'(ix), d, 4'(rk), d[0] ^ 1'(ix), bit'(m), bit'(f),
                     (ix % 3) + 1, 0, "R1 R2 R3 R4 R5");
            end

    // R6: one-cycle busy drop during the busy period
    for (int i = 0; i < 4; i++)
      single(3'(i + 3), 16'h2C5A << i, 4'd2, 1'b1, 1, bit'(i % 2), 2, 1, "R6 glitch");
    // R7: controller that never raises busy
    single(3'd5, 16'h0F0F, 4'd1, 1'b0, 1, 1, 0, 0, "R7 zero latency");

    // R8 R9: walks over every rank count and table row
    for (int n = 0; n < 5; n++)
      for (int ps = 0; ps < 4; ps++)
        run_walk(2'(ps), n, bit'((n + ps) % 2 == 0 || n == 2), bit'(ps % 2), 0);
    // R10: start and single request injected during a walk
    run_walk(2'd1, 3, 1, 1, 1);
    run_walk(2'd2, 2, 1, 0, 1);

    summary();
  end
endmodule